// File: doc/BRIEF.md
# Timer burst register window

This block sits on the register side of a timer and gives a DMA engine one fixed word address, the window, through which it can write or read a run of consecutive timer registers. A burst control register sets a starting register offset and a transfer count. Each access to the window is sent to the register at the start offset plus a running index. The index then steps forward and returns to zero once the burst is complete. The window holds no data of its own.

An update-event pulse, which stands in for a counter overflow, raises a DMA request when the update request enable bit is set. That request is served by one full burst. It stays high until the engine acknowledges the last transfer. An update that arrives while a burst is still running is remembered and served by a second burst, which starts again at the base offset. The timer registers themselves are a plain bank of 16-bit registers on a word-addressed bus.

Top module: `tbw_top`

## Requirements
- R1: After reset, every bank register, the burst control register and the enable register read zero, and `dma_req` is low.
- R2: The burst control register (word address 18) holds the length code in bits 12:8 and the base offset in bits 4:0. All other bits read as zero.
- R3: A write to the window (word address 19) stores the data in bank register base+index, and the index then steps by one. The same register reads back the value through its direct address.
- R4: A read of the window returns bank register base+index on `bus_rdata` in the same cycle as the read strobe, and the index then steps by one.
- R5: A length code n gives n+1 window accesses per burst, after which the index returns to zero. Codes above 17 act as 17, which gives 18 accesses.
- R6: A write to the burst control register sets the index back to zero.
- R7: Bit 0 of the enable register (word address 20) gates update events. With the bit at 1, an `upd_evt` pulse drives `dma_req` high from the next cycle. With the bit at 0, the pulse has no effect.
- R8: `dma_req` stays high until a window access with `dma_ack` high is made at the last index of the burst, and goes low in the following cycle.
- R9: An update event that arrives during a burst, including in the cycle of its final acknowledge, is held pending. `dma_req` then stays high for one more full burst, which starts from the base offset.
- R10: A window access whose target base+index is 18 or higher writes nothing and reads zero. It still steps the index, and no register changes.
- R11: Direct accesses to any address other than the window leave the index unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Word address of the access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the strobe cycle, zero when there is no read |
| upd_evt | input | 1 | Update event pulse |
| dma_req | output | 1 | Update DMA request |
| dma_ack | input | 1 | DMA acknowledge, given together with each window access |

## Verification
The bench targets these corner cases:
- The index wrap after exactly n+1 accesses, including the clamped length code 31. A design that misses this would send the nineteenth word to the wrong register.
- An update event that arrives mid-burst or in the same cycle as the final acknowledge. A design that gets this wrong would drop `dma_req` and lose a burst.
- A burst whose tail runs past the bank. A wrong design would corrupt the control registers or return stale data.
- A control write or direct accesses in the middle of a burst. This exposes an index that fails to reset, or that advances on non-window traffic.

// File: rtl/tbw_pkg.sv
package tbw_pkg;
   localparam int LEN_W    = 5;
   localparam int BASE_W   = 5;
   localparam int LEN_LSB  = 8;
   localparam int BASE_LSB = 0;
   localparam int MAX_CODE = 17;

   typedef struct packed {
      logic [LEN_W-1:0]  len_code;
      logic [BASE_W-1:0] base;
   } burst_cfg_t;
endpackage

// File: rtl/tbw_burst_seq.sv
module tbw_burst_seq
   import tbw_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int TGT_W     = 6,
   parameter bit CLAMP_LEN = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_wr,
   input  logic [LEN_W-1:0]    cfg_len_in,
   input  logic [BASE_W-1:0]   cfg_base_in,
   input  logic                win_acc,
   output logic [DATA_W-1:0]   cfg_view,
   output logic [TGT_W-1:0]    tgt,
   output logic                last
);
   burst_cfg_t        cfg_q;
   logic [LEN_W-1:0]  idx_q;
   logic [LEN_W-1:0]  len_eff;

   generate
      if (CLAMP_LEN) begin : g_clamp
         assign len_eff = (cfg_q.len_code > LEN_W'(MAX_CODE)) ? LEN_W'(MAX_CODE) : cfg_q.len_code;
      end else begin : g_raw
         assign len_eff = cfg_q.len_code;
      end
   endgenerate

   assign last = (idx_q == len_eff);
   assign tgt  = TGT_W'(cfg_q.base) + TGT_W'(idx_q);

   always_comb begin
      cfg_view = '0;
      cfg_view[LEN_LSB +: LEN_W]   = cfg_q.len_code;
      cfg_view[BASE_LSB +: BASE_W] = cfg_q.base;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q <= '0;
         idx_q <= '0;
      end else if (cfg_wr) begin
         cfg_q.len_code <= cfg_len_in;
         cfg_q.base     <= cfg_base_in;
         idx_q          <= '0;
      end else if (win_acc) begin
         idx_q <= last ? '0 : idx_q + 1'b1;
      end
   end

   // R5: index never passes the effective burst length
   a_r5_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q <= len_eff);

   // R6: control write returns index to zero
   a_r6_idx_clear: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> (idx_q == '0));

   // R11: index moves only on window access or control write
   a_r11_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_wr && !win_acc) |=> $stable(idx_q));
endmodule

// File: rtl/tbw_req_ctrl.sv
module tbw_req_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic en_wr,
   input  logic en_wdata,
   input  logic upd_evt,
   input  logic burst_done,
   output logic en_q,
   output logic dma_req
);
   logic pend_q;
   logic upd_ok;

   assign upd_ok = upd_evt && en_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         dma_req <= 1'b0;
         pend_q  <= 1'b0;
      end else begin
         if (en_wr) en_q <= en_wdata;
         if (burst_done) begin
            if (pend_q) begin
               dma_req <= 1'b1;
               pend_q  <= upd_ok;
            end else begin
               dma_req <= upd_ok;
            end
         end else if (upd_ok) begin
            if (dma_req) pend_q  <= 1'b1;
            else         dma_req <= 1'b1;
         end
      end
   end

   // R8: request held until final acknowledged transfer
   a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_req && !burst_done) |=> dma_req);

   // R7: request only rises from an enabled update event
   a_r7_req_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dma_req) |-> $past(upd_evt && en_q));

   // R9: a pending event keeps the request up past the burst end
   a_r9_pend_served: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && burst_done) |=> dma_req);
endmodule

// File: rtl/tbw_reg_bank.sv
module tbw_reg_bank #(
   parameter int DATA_W   = 16,
   parameter int NUM_REGS = 18,
   parameter int IDX_W    = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rdata
);
   logic [NUM_REGS-1:0][DATA_W-1:0] q;

   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n)                                q[i] <= '0;
            else if (wr_en && wr_idx == IDX_W'(i))     q[i] <= wdata;
         end
      end
   endgenerate

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_REGS; i++)
         if (rd_idx == IDX_W'(i)) rdata = q[i];
   end

   // R10: writes aimed past the bank change nothing
   a_r10_oob_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx >= IDX_W'(NUM_REGS)) |=> $stable(q));
endmodule

// File: rtl/tbw_top.sv
module tbw_top
   import tbw_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int ADDR_W    = 5,
   parameter int NUM_REGS  = 18,
   parameter int CFG_ADDR  = 18,
   parameter int WIN_ADDR  = 19,
   parameter int EN_ADDR   = 20,
   parameter bit CLAMP_LEN = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              upd_evt,
   output logic              dma_req,
   input  logic              dma_ack
);
   localparam int TGT_W = $clog2((1 << BASE_W) + MAX_CODE + 1);

   initial begin : p_param_chk
      assert (DATA_W >= LEN_LSB + LEN_W) else $error("DATA_W too narrow for control fields");
      assert (CFG_ADDR >= NUM_REGS && WIN_ADDR >= NUM_REGS && EN_ADDR >= NUM_REGS)
         else $error("special addresses overlap the bank");
      assert (CFG_ADDR != WIN_ADDR && CFG_ADDR != EN_ADDR && WIN_ADDR != EN_ADDR)
         else $error("special addresses must differ");
      assert (TGT_W >= ADDR_W) else $error("target index narrower than address");
      assert (EN_ADDR < (1 << ADDR_W)) else $error("address width too small");
   end

   logic              sel_cfg, sel_win, sel_en;
   logic              win_acc, last, burst_done, en_q;
   logic [TGT_W-1:0]  tgt, bank_idx;
   logic [DATA_W-1:0] cfg_view, bank_rdata;

   assign sel_cfg    = (bus_addr == ADDR_W'(CFG_ADDR));
   assign sel_win    = (bus_addr == ADDR_W'(WIN_ADDR));
   assign sel_en     = (bus_addr == ADDR_W'(EN_ADDR));
   assign win_acc    = sel_win && (bus_rd || bus_wr);
   assign burst_done = win_acc && dma_ack && last;
   assign bank_idx   = sel_win ? tgt : TGT_W'(bus_addr);

   tbw_burst_seq #(
      .DATA_W(DATA_W), .TGT_W(TGT_W), .CLAMP_LEN(CLAMP_LEN)
   ) seq_i (
      .clk(clk), .rst_n(rst_n),
      .cfg_wr(bus_wr && sel_cfg),
      .cfg_len_in(bus_wdata[LEN_LSB +: LEN_W]),
      .cfg_base_in(bus_wdata[BASE_LSB +: BASE_W]),
      .win_acc(win_acc),
      .cfg_view(cfg_view), .tgt(tgt), .last(last)
   );

   tbw_req_ctrl req_i (
      .clk(clk), .rst_n(rst_n),
      .en_wr(bus_wr && sel_en), .en_wdata(bus_wdata[0]),
      .upd_evt(upd_evt), .burst_done(burst_done),
      .en_q(en_q), .dma_req(dma_req)
   );

   tbw_reg_bank #(
      .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(TGT_W)
   ) bank_i (
      .clk(clk), .rst_n(rst_n),
      .wr_en(bus_wr && !sel_cfg && !sel_en),
      .wr_idx(bank_idx), .wdata(bus_wdata),
      .rd_idx(bank_idx), .rdata(bank_rdata)
   );

   always_comb begin
      if (!bus_rd)      bus_rdata = '0;
      else if (sel_cfg) bus_rdata = cfg_view;
      else if (sel_en)  bus_rdata = DATA_W'(en_q);
      else              bus_rdata = bank_rdata;
   end

   // R2: reserved control bits always read zero
   always_comb begin
      if (rst_n && bus_rd && sel_cfg)
         a_r2_rsv_zero: assert (bus_rdata[15:13] == 3'b000 && bus_rdata[7:5] == 3'b000);
   end
endmodule

// File: tb/tbw_top_tb_top.sv
module tbw_top_tb_top;
   localparam int CLK_P = 10;
   localparam int NREG  = 18;
   localparam int A_CFG = 18;
   localparam int A_WIN = 19;
   localparam int A_EN  = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic        bus_rd = 1'b0, bus_wr = 1'b0, upd_evt = 1'b0, dma_ack = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        dma_req;

   int checks = 0, errors = 0;
   bit done = 0;

   int m_bank[NREG];
   int m_len, m_base, m_idx, m_en, m_out;

   always #(CLK_P/2) clk = ~clk;

   tbw_top dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .upd_evt(upd_evt), .dma_req(dma_req), .dma_ack(dma_ack)
   );

   function automatic int eff_len();
      return (m_len > 17) ? 17 : m_len;
   endfunction

   function automatic int exp_read(int a);
      int t;
      if (a == A_CFG) return (m_len << 8) | m_base;
      if (a == A_EN)  return m_en;
      t = (a == A_WIN) ? m_base + m_idx : a;
      return (t < NREG) ? m_bank[t] : 0;
   endfunction

   task automatic step(input bit rd, input bit wr, input int a, input int d,
                       input bit ack, input bit upd, input string tag);
      bit win, fin;
      int t, ex;
      bus_rd = rd; bus_wr = wr; bus_addr = 5'(a); bus_wdata = 16'(d);
      dma_ack = ack; upd_evt = upd;
      @(negedge clk);
      checks++;
      if (dma_req !== (m_out > 0)) begin
         errors++;
         $display("FAIL %s dma_req got %0b expected %0b", tag, dma_req, m_out > 0);
      end
      if (rd) begin
         ex = exp_read(a);
         checks++;
         if (bus_rdata !== 16'(ex)) begin
            errors++;
            $display("FAIL %s read addr %0d got %h expected %h", tag, a, bus_rdata, 16'(ex));
         end
      end
      win = (rd || wr) && a == A_WIN;
      fin = win && ack && (m_idx == eff_len());
      t = m_base + m_idx;
      if (wr) begin
         if (a == A_CFG) begin
            m_len = (d >> 8) & 31; m_base = d & 31; m_idx = 0;
         end else if (a == A_EN) m_en = d & 1;
         else if (a == A_WIN) begin
            if (t < NREG) m_bank[t] = d & 16'hFFFF;
         end else if (a < NREG) m_bank[a] = d & 16'hFFFF;
      end
      if (win) m_idx = (m_idx == eff_len()) ? 0 : m_idx + 1;
      if (fin) m_out--;
      if (upd && m_en_old(wr, a)) m_out = (m_out == 0) ? 1 : 2;
      @(posedge clk); #1;
      bus_rd = 0; bus_wr = 0; dma_ack = 0; upd_evt = 0;
   endtask

   int en_before;
   function automatic bit m_en_old(bit wr, int a);
      return en_before != 0;
   endfunction

   task automatic op(input bit rd, input bit wr, input int a, input int d,
                     input bit ack, input bit upd, input string tag);
      en_before = m_en;
      step(rd, wr, a, d, ack, upd, tag);
   endtask

   task automatic wr(input int a, input int d, input string tag); op(0, 1, a, d, 0, 0, tag); endtask
   task automatic rd(input int a, input string tag); op(1, 0, a, 0, 0, 0, tag); endtask
   task automatic idle(input string tag); op(0, 0, 0, 0, 0, 0, tag); endtask
   task automatic upd(input string tag); op(0, 0, 0, 0, 0, 1, tag); endtask
   task automatic winw(input int d, input bit ack, input string tag); op(0, 1, A_WIN, d, ack, 0, tag); endtask
   task automatic winr(input string tag); op(1, 0, A_WIN, 0, 0, 0, tag); endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(CLK_P * 200000);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      for (int i = 0; i < NREG; i++) m_bank[i] = 0;
      m_len = 0; m_base = 0; m_idx = 0; m_en = 0; m_out = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;

      // R1 reset state
      rd(A_CFG, "R1"); rd(A_EN, "R1"); rd(0, "R1"); rd(17, "R1"); rd(A_WIN, "R1");
      // R2 field layout
      wr(A_CFG, 16'hFFFF, "R2"); rd(A_CFG, "R2");
      wr(A_CFG, 16'h020E, "R2"); rd(A_CFG, "R2");
      // R7 gating
      upd("R7"); idle("R7"); idle("R7");
      wr(A_EN, 1, "R7"); rd(A_EN, "R7");
      upd("R7"); idle("R7");
      // R3 / R8 one burst
      winw(16'h1111, 1, "R8"); winw(16'h2222, 1, "R8"); winw(16'h3333, 1, "R8");
      idle("R8");
      rd(14, "R3"); rd(15, "R3"); rd(16, "R3");
      // R9 event during burst
      upd("R9"); winw(16'h7777, 1, "R9"); upd("R9");
      winw(16'h8888, 1, "R9"); winw(16'h9999, 1, "R9"); idle("R9");
      winw(16'h4444, 1, "R9"); winw(16'h5555, 1, "R9"); winw(16'h6666, 1, "R9");
      idle("R9"); rd(14, "R9"); rd(15, "R9"); rd(16, "R9");
      // R4 window reads and R5 wrap
      winr("R4"); winr("R4"); winr("R4"); winr("R5");
      // R6 control write mid burst
      wr(A_CFG, 16'h020E, "R6"); winr("R6"); winr("R6");
      wr(A_CFG, 16'h020E, "R6"); winr("R6");
      // R11 direct traffic leaves index
      wr(3, 16'hABCD, "R11"); rd(5, "R11"); rd(3, "R11"); rd(A_EN, "R11"); rd(A_CFG, "R11");
      winr("R11"); winr("R11");
      // R10 burst tail past the bank
      wr(A_CFG, 16'h0310, "R10");
      winw(16'h00A0, 0, "R10"); winw(16'h00A1, 0, "R10");
      winw(16'h00A2, 0, "R10"); winw(16'h00A3, 0, "R10");
      rd(16, "R10"); rd(17, "R10"); rd(A_CFG, "R10"); rd(A_EN, "R10");
      winr("R10"); winr("R10"); winr("R10"); winr("R10");
      // R5 clamped length code
      wr(A_CFG, 16'h1F00, "R5"); upd("R5"); idle("R5");
      for (int i = 0; i < 18; i++) winw(16'h0100 + i, 1, "R5");
      idle("R8");
      winw(16'h0BAD, 0, "R5"); rd(0, "R5"); rd(17, "R5"); rd(1, "R5");
      // R9 event in cycle of final acknowledge
      wr(A_CFG, 16'h000E, "R9"); upd("R9"); idle("R9");
      op(0, 1, A_WIN, 16'h0C01, 1, 1, "R9"); idle("R9");
      winw(16'h0C02, 1, "R9"); idle("R9"); rd(14, "R9");
      // R7 disable again
      wr(A_EN, 0, "R7"); upd("R7"); idle("R7"); idle("R7");
      finish_run();
   end
endmodule